// File: doc/BRIEF.md
# FM Register Write Pacer

This block sits between a host-side byte interface and the register port of an FM synthesizer. The host delivers an index (register address) byte, then a data byte. Each byte is captured in its own one-deep buffer. The block then forwards it to the synthesizer as a complete bus cycle: chip select first, then a write strobe several clocks wide, with the address-select line and the data bus held stable around the strobe. After each write, the block keeps the synthesizer bus quiet for the settle time that the synthesizer needs. That time is short after an index write and long after a data write.

A single busy flag, `host_wait`, covers the whole transaction. It rises when the index byte is captured and stays high through the index settle time, the buffered data write and the data settle time. The host therefore checks the flag once, then sends both bytes back to back. The host can also request the synthesizer status byte. The block runs a read cycle on the bus and returns the captured byte with a one-cycle valid pulse. A read never raises the busy flag.

All timing is derived from the clock frequency in MHz and the settle times in microseconds, which are parameters.

Top module: `fm_write_pacer`

## Requirements
- R1: After reset, `fm_cs_n`, `fm_we_n` and `fm_rd_n` are 1, `host_wait` is 0, `host_stat_vld` is 0, and `host_stat`, `fm_a0` and `fm_wdata` are 0.
- R2: Timing of a write cycle is fixed relative to the clock edge that samples the host strobe. `fm_cs_n` falls one clock after that edge, and the captured byte appears on `fm_wdata` at the same time. `fm_a0` is 0 for an index write and 1 for a data write. `fm_we_n` is low for STROBE_CYC clocks, starting one clock after `fm_cs_n` falls. `fm_cs_n` returns high one clock after `fm_we_n` rises. `fm_a0` and `fm_wdata` do not change while `fm_cs_n` is low.
- R3: After an index write, the next synthesizer access starts its strobe exactly STROBE_CYC+3+CLK_MHZ*IDX_SETTLE_US clocks after the index strobe started, provided that access is already pending.
- R4: After a data write, the next pending access starts its strobe exactly STROBE_CYC+3+CLK_MHZ*DAT_SETTLE_US clocks after the data strobe started.
- R5: `host_wait` is 1 from the clock edge that captures an index byte. When the data byte follows before the index settle time ends, `host_wait` stays 1 without a break until the data settle time ends, and then falls once.
- R6: A data byte received while the index is still being paced is held in its buffer. It is issued as the next write after the index settle time.
- R7: A data byte with no index before it is issued on its own as a write with `fm_a0`=1.
- R8: A status request runs a read cycle with `fm_a0`=0 and `fm_rd_n` low for STROBE_CYC clocks. The block captures `fm_rdata` in the last clock of that strobe and shows it on `host_stat`, with `host_stat_vld` high for the one following clock. A read leaves `host_wait` at 0.
- R9: When the block is free and several requests are pending, it serves a pending index first, then a pending data byte, then a pending status read.
- R10: Reset during a transaction ends it at once. It drops `host_wait` and discards any buffered byte, so no further write reaches the synthesizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idx_wr | input | 1 | One-clock pulse: `host_din` holds an index byte |
| host_dat_wr | input | 1 | One-clock pulse: `host_din` holds a data byte |
| host_stat_rd | input | 1 | One-clock pulse: request the status byte |
| host_din | input | DW | Byte from the host |
| host_wait | output | 1 | Busy flag for the index-plus-data transaction |
| host_stat | output | DW | Last status byte read from the synthesizer |
| host_stat_vld | output | 1 | One-clock pulse when `host_stat` is updated |
| fm_a0 | output | 1 | Address select: 0 index/status, 1 data |
| fm_cs_n | output | 1 | Chip select, active low |
| fm_we_n | output | 1 | Write strobe, active low |
| fm_rd_n | output | 1 | Read strobe, active low |
| fm_wdata | output | DW | Write data to the synthesizer |
| fm_rdata | input | DW | Status byte from the synthesizer |

## Verification
Every result has a fixed latency measured from the clock edge that samples a host pulse. The busy flag rises at that edge. Chip select falls one clock later and the strobe one clock after that. The status valid pulse comes STROBE_CYC+2 clocks after the read cycle starts. The next strobe follows after a settle window of exactly the length stated in R3 or R4. A behavioural timeline model in the bench advances on the same edges and is compared with every output at each falling edge, so an output that changes one clock early or late is reported. Separate checks compare the spacing between strobe starts and the order of issued accesses with the values given in R3, R4 and R9.

// File: rtl/fm_pacer_pkg.sv
package fm_pacer_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_SETTLE
   } phase_e;

   localparam int SLOT_IDX  = 0;
   localparam int SLOT_DAT  = 1;
   localparam int NUM_SLOTS = 2;

   // bits needed to hold the value (n - 1)
   function automatic int cnt_bits(input int n);
      return (n < 3) ? 1 : $clog2(n);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/fm_pacer_slots.sv
module fm_pacer_slots #(
   parameter int DW = 8,
   parameter int NS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NS-1:0]    wr,
   input  logic [DW-1:0]    din,
   input  logic [NS-1:0]    take,
   output logic [NS-1:0]    valid,
   output logic [NS*DW-1:0] bytes
);

   for (genvar s = 0; s < NS; s++) begin : g_slot
      logic          v_q;
      logic [DW-1:0] b_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            b_q <= '0;
         end else if (wr[s]) begin
            v_q <= 1'b1;
            b_q <= din;
         end else if (take[s]) begin
            v_q <= 1'b0;
         end
      end

      assign valid[s]           = v_q;
      assign bytes[s*DW +: DW]  = b_q;

      AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
         take[s] |-> v_q); // R9
   end

endmodule

// File: rtl/fm_pacer_timer.sv
module fm_pacer_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/fm_pacer_seq.sv
module fm_pacer_seq
   import fm_pacer_pkg::*;
#(
   parameter int DW         = 8,
   parameter int STROBE_CYC = 4,
   parameter int IDX_CYC    = 500,
   parameter int DAT_CYC    = 3500,
   parameter int CW         = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      slot_v,
   input  logic [2*DW-1:0] slot_b,
   input  logic            rd_req,
   input  logic [DW-1:0]   fm_rdata,
   output logic [1:0]      take,
   output logic            busy_wr,
   output logic            fm_a0,
   output logic            fm_cs_n,
   output logic            fm_we_n,
   output logic            fm_rd_n,
   output logic [DW-1:0]   fm_wdata,
   output logic [DW-1:0]   stat_q,
   output logic            stat_vld
);

   localparam logic [CW-1:0] LD_STB = CW'(STROBE_CYC - 1);
   localparam logic [CW-1:0] LD_IDX = CW'(IDX_CYC - 1);
   localparam logic [CW-1:0] LD_DAT = CW'(DAT_CYC - 1);

   phase_e        phase_q;
   logic          op_wr_q;
   logic          a0_q;
   logic [DW-1:0] d_q;
   logic          rd_pend_q;
   logic          idle;
   logic          rd_take;
   logic          t_load;
   logic [CW-1:0] t_val;
   logic          t_zero;

   assign idle    = (phase_q == PH_IDLE);
   assign take[SLOT_IDX] = idle & slot_v[SLOT_IDX];
   assign take[SLOT_DAT] = idle & ~slot_v[SLOT_IDX] & slot_v[SLOT_DAT];
   assign rd_take = idle & ~(|slot_v) & rd_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_pend_q <= 1'b0;
      else if (rd_req)   rd_pend_q <= 1'b1;
      else if (rd_take)  rd_pend_q <= 1'b0;
   end

   assign t_load = (phase_q == PH_SETUP) | ((phase_q == PH_HOLD) & op_wr_q);
   assign t_val  = (phase_q == PH_SETUP) ? LD_STB : (a0_q ? LD_DAT : LD_IDX);

   fm_pacer_timer #(.CW(CW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_wr_q <= 1'b0;
         a0_q    <= 1'b0;
         d_q     <= '0;
         stat_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (|take) begin
                  phase_q <= PH_SETUP;
                  op_wr_q <= 1'b1;
                  a0_q    <= take[SLOT_DAT];
                  d_q     <= take[SLOT_DAT] ? slot_b[SLOT_DAT*DW +: DW]
                                            : slot_b[SLOT_IDX*DW +: DW];
               end else if (rd_take) begin
                  phase_q <= PH_SETUP;
                  op_wr_q <= 1'b0;
                  a0_q    <= 1'b0;
               end
            end
            PH_SETUP:  phase_q <= PH_STROBE;
            PH_STROBE: begin
               if (t_zero) begin
                  if (!op_wr_q) stat_q <= fm_rdata;
                  phase_q <= PH_HOLD;
               end
            end
            PH_HOLD:   phase_q <= op_wr_q ? PH_SETTLE : PH_IDLE;
            PH_SETTLE: if (t_zero) phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign fm_cs_n  = ~((phase_q == PH_SETUP) | (phase_q == PH_STROBE) | (phase_q == PH_HOLD));
   assign fm_we_n  = ~((phase_q == PH_STROBE) & op_wr_q);
   assign fm_rd_n  = ~((phase_q == PH_STROBE) & ~op_wr_q);
   assign fm_a0    = a0_q;
   assign fm_wdata = d_q;
   assign stat_vld = (phase_q == PH_HOLD) & ~op_wr_q;
   assign busy_wr  = op_wr_q & ~idle;

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fm_we_n || !fm_rd_n) |-> !fm_cs_n); // R2
   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fm_cs_n && !$past(fm_cs_n)) |-> ($stable(fm_a0) && $stable(fm_wdata))); // R2
   AST_WE_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !fm_we_n |-> fm_rd_n); // R8
   AST_VLD_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> !$past(fm_rd_n)); // R8

endmodule

// File: rtl/fm_write_pacer.sv
module fm_write_pacer
   import fm_pacer_pkg::*;
#(
   parameter int DW            = 8,
   parameter int CLK_MHZ       = 100,
   parameter int IDX_SETTLE_US = 5,
   parameter int DAT_SETTLE_US = 35,
   parameter int STROBE_CYC    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_idx_wr,
   input  logic          host_dat_wr,
   input  logic          host_stat_rd,
   input  logic [DW-1:0] host_din,
   output logic          host_wait,
   output logic [DW-1:0] host_stat,
   output logic          host_stat_vld,
   output logic          fm_a0,
   output logic          fm_cs_n,
   output logic          fm_we_n,
   output logic          fm_rd_n,
   output logic [DW-1:0] fm_wdata,
   input  logic [DW-1:0] fm_rdata
);

   localparam int IDX_CYC = CLK_MHZ * IDX_SETTLE_US;
   localparam int DAT_CYC = CLK_MHZ * DAT_SETTLE_US;
   localparam int CW      = cnt_bits(max3(STROBE_CYC, IDX_CYC, DAT_CYC));
   localparam int GW      = $clog2(max3(IDX_CYC, DAT_CYC, 1) + 8);

   if (DW < 1) begin : g_bad_dw
      $error("fm_write_pacer: DW must be at least 1");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("fm_write_pacer: STROBE_CYC must be at least 1");
   end
   if (IDX_CYC < 1 || DAT_CYC < 1) begin : g_bad_settle
      $error("fm_write_pacer: settle times must give at least one clock");
   end

   logic [NUM_SLOTS-1:0]    slot_v;
   logic [NUM_SLOTS*DW-1:0] slot_b;
   logic [NUM_SLOTS-1:0]    take;
   logic                    busy_wr;

   fm_pacer_slots #(.DW(DW), .NS(NUM_SLOTS)) i_slots (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    ({host_dat_wr, host_idx_wr}),
      .din   (host_din),
      .take  (take),
      .valid (slot_v),
      .bytes (slot_b)
   );

   fm_pacer_seq #(
      .DW(DW), .STROBE_CYC(STROBE_CYC), .IDX_CYC(IDX_CYC),
      .DAT_CYC(DAT_CYC), .CW(CW)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_v   (slot_v),
      .slot_b   (slot_b),
      .rd_req   (host_stat_rd),
      .fm_rdata (fm_rdata),
      .take     (take),
      .busy_wr  (busy_wr),
      .fm_a0    (fm_a0),
      .fm_cs_n  (fm_cs_n),
      .fm_we_n  (fm_we_n),
      .fm_rd_n  (fm_rd_n),
      .fm_wdata (fm_wdata),
      .stat_q   (host_stat),
      .stat_vld (host_stat_vld)
   );

   assign host_wait = (|slot_v) | busy_wr;

   // settle-gap watch: clocks since the last write strobe ended
   logic [GW-1:0] gap_q;
   logic          gap_a0_q;
   logic          seen_wr_q;
   logic          cs_prev_q;
   logic [GW-1:0] gap_need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q     <= '0;
         gap_a0_q  <= 1'b0;
         seen_wr_q <= 1'b0;
         cs_prev_q <= 1'b1;
      end else begin
         cs_prev_q <= fm_cs_n;
         if (!fm_we_n) begin
            gap_q     <= '0;
            gap_a0_q  <= fm_a0;
            seen_wr_q <= 1'b1;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   assign gap_need = gap_a0_q ? GW'(DAT_CYC + 1) : GW'(IDX_CYC + 1);

   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!fm_cs_n && cs_prev_q && seen_wr_q) |-> (gap_q >= gap_need)); // R3, R4
   AST_WAIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !fm_we_n |-> host_wait); // R5
   AST_WAIT_AFTER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      host_idx_wr |=> host_wait); // R5

endmodule

// File: tb/test_fm_write_pacer.sv
`timescale 1ns/1ps
module test_fm_write_pacer;

   localparam int DW      = 8;
   localparam int CLK_MHZ = 100;
   localparam int IDX_US  = 5;
   localparam int DAT_US  = 35;
   localparam int S       = 4;
   localparam int NI      = CLK_MHZ * IDX_US;
   localparam int ND      = CLK_MHZ * DAT_US;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_idx_wr = 1'b0, host_dat_wr = 1'b0, host_stat_rd = 1'b0;
   logic [DW-1:0] host_din = '0;
   logic [DW-1:0] fm_rdata = '0;
   logic          host_wait, host_stat_vld, fm_a0, fm_cs_n, fm_we_n, fm_rd_n;
   logic [DW-1:0] host_stat, fm_wdata;

   always #5 clk = ~clk;

   fm_write_pacer #(
      .DW(DW), .CLK_MHZ(CLK_MHZ), .IDX_SETTLE_US(IDX_US),
      .DAT_SETTLE_US(DAT_US), .STROBE_CYC(S)
   ) i_fm_write_pacer (
      .clk(clk), .rst_n(rst_n), .host_idx_wr(host_idx_wr), .host_dat_wr(host_dat_wr),
      .host_stat_rd(host_stat_rd), .host_din(host_din), .host_wait(host_wait),
      .host_stat(host_stat), .host_stat_vld(host_stat_vld), .fm_a0(fm_a0),
      .fm_cs_n(fm_cs_n), .fm_we_n(fm_we_n), .fm_rd_n(fm_rd_n),
      .fm_wdata(fm_wdata), .fm_rdata(fm_rdata)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural timeline model ----------------
   // act: 0 none, 1 index write, 2 data write, 3 status read; t = clocks into op
   int m_act = 0, m_t = 0;
   bit m_iv = 0, m_dv = 0, m_rv = 0;
   int m_ib = 0, m_db = 0, m_a0 = 0, m_d = 0, m_stat = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_t = 0; m_iv = 0; m_dv = 0; m_rv = 0;
         m_ib = 0; m_db = 0; m_a0 = 0; m_d = 0; m_stat = 0;
      end else begin
         if (m_act == 0) begin
            if (m_iv) begin m_act = 1; m_a0 = 0; m_d = m_ib; m_iv = 0; m_t = 0; end
            else if (m_dv) begin m_act = 2; m_a0 = 1; m_d = m_db; m_dv = 0; m_t = 0; end
            else if (m_rv) begin m_act = 3; m_a0 = 0; m_rv = 0; m_t = 0; end
         end else begin
            int end_t;
            if (m_act == 3 && m_t == S) m_stat = fm_rdata;
            m_t++;
            end_t = (m_act == 3) ? S + 2 : (S + 2 + ((m_act == 1) ? NI : ND));
            if (m_t == end_t) m_act = 0;
         end
         if (host_idx_wr) begin m_iv = 1; m_ib = host_din; end
         if (host_dat_wr) begin m_dv = 1; m_db = host_din; end
         if (host_stat_rd) m_rv = 1;
      end
   end

   // ---------------- per-cycle comparison and access log ----------------
   int cyc = 0;
   int lg_kind[$];
   int lg_byte[$];
   int lg_time[$];
   int wait_falls = 0, wait_rises = 0;
   logic we_prev = 1'b1, rd_prev = 1'b1, wait_prev = 1'b0;

   always @(negedge clk) begin
      bit e_cs, e_we, e_rd, e_vld, e_wait;
      cyc++;
      e_cs   = !(m_act != 0 && m_t <= S + 1);
      e_we   = !((m_act == 1 || m_act == 2) && m_t >= 1 && m_t <= S);
      e_rd   = !(m_act == 3 && m_t >= 1 && m_t <= S);
      e_vld  = (m_act == 3 && m_t == S + 1);
      e_wait = m_iv || m_dv || m_act == 1 || m_act == 2;
      if (rst_n) begin
         check(fm_cs_n == e_cs,   "R2", "fm_cs_n", fm_cs_n, e_cs);
         check(fm_we_n == e_we,   "R2", "fm_we_n", fm_we_n, e_we);
         check(fm_rd_n == e_rd,   "R8", "fm_rd_n", fm_rd_n, e_rd);
         check(fm_a0 == m_a0[0],  "R2", "fm_a0", fm_a0, m_a0);
         check(fm_wdata == DW'(m_d), "R2", "fm_wdata", fm_wdata, m_d);
         check(host_wait == e_wait, "R5", "host_wait", host_wait, e_wait);
         check(host_stat_vld == e_vld, "R8", "host_stat_vld", host_stat_vld, e_vld);
         check(host_stat == DW'(m_stat), "R8", "host_stat", host_stat, m_stat);
      end
      if (we_prev && !fm_we_n) begin
         lg_kind.push_back(fm_a0 ? 2 : 1); lg_byte.push_back(fm_wdata); lg_time.push_back(cyc);
      end
      if (rd_prev && !fm_rd_n) begin
         lg_kind.push_back(3); lg_byte.push_back(0); lg_time.push_back(cyc);
      end
      if (wait_prev && !host_wait) wait_falls++;
      if (!wait_prev && host_wait) wait_rises++;
      we_prev = fm_we_n; rd_prev = fm_rd_n; wait_prev = host_wait;
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_idx(input int b);
      host_din = DW'(b); host_idx_wr = 1'b1; step(1); host_idx_wr = 1'b0;
   endtask
   task automatic pulse_dat(input int b);
      host_din = DW'(b); host_dat_wr = 1'b1; step(1); host_dat_wr = 1'b0;
   endtask
   task automatic pulse_rd();
      host_stat_rd = 1'b1; step(1); host_stat_rd = 1'b0;
   endtask
   task automatic clear_log();
      lg_kind.delete(); lg_byte.delete(); lg_time.delete();
      wait_falls = 0; wait_rises = 0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=0", 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1: reset state
      check(fm_cs_n && fm_we_n && fm_rd_n, "R1", "strobes idle", {fm_cs_n, fm_we_n, fm_rd_n}, 7);
      check(!host_wait && !host_stat_vld, "R1", "wait/vld", {host_wait, host_stat_vld}, 0);
      check(host_stat == 0 && fm_wdata == 0 && !fm_a0, "R1", "data regs", host_stat, 0);
      rst_n = 1'b1;
      step(3);

      // R2 R3 R4 R5 R6: index, data, read back to back after one poll
      clear_log();
      fm_rdata = 8'h3C;
      pulse_idx(8'hB0);
      pulse_dat(8'h5A);
      pulse_rd();
      step(S + NI + ND + 40);
      check(lg_kind.size() == 3, "R6", "access count", lg_kind.size(), 3);
      if (lg_kind.size() == 3) begin
         check(lg_kind[0] == 1 && lg_byte[0] == 8'hB0, "R2", "index write", lg_byte[0], 8'hB0);
         check(lg_kind[1] == 2 && lg_byte[1] == 8'h5A, "R6", "buffered data write", lg_byte[1], 8'h5A);
         check(lg_time[1] - lg_time[0] == S + 3 + NI, "R3", "index settle spacing",
               lg_time[1] - lg_time[0], S + 3 + NI);
         check(lg_time[2] - lg_time[1] == S + 3 + ND, "R4", "data settle spacing",
               lg_time[2] - lg_time[1], S + 3 + ND);
      end
      check(wait_rises == 1 && wait_falls == 1, "R5", "single wait pulse",
            wait_rises * 10 + wait_falls, 11);
      check(host_stat == 8'h3C, "R8", "status after queued read", host_stat, 8'h3C);

      // R7: data with no index first
      clear_log();
      pulse_dat(8'hE7);
      step(S + ND + 20);
      check(lg_kind.size() == 1 && lg_kind[0] == 2, "R7", "lone data uses a0=1",
            lg_kind.size() > 0 ? lg_kind[0] : -1, 2);
      check(lg_byte.size() == 1 && lg_byte[0] == 8'hE7, "R7", "lone data byte",
            lg_byte.size() > 0 ? lg_byte[0] : -1, 8'hE7);

      // R8: status read alone does not raise wait
      clear_log();
      fm_rdata = 8'hA5;
      pulse_rd();
      step(S + 8);
      check(host_stat == 8'hA5, "R8", "status byte", host_stat, 8'hA5);
      check(wait_rises == 0, "R8", "wait during read", wait_rises, 0);

      // R9: priority among pending requests while busy
      clear_log();
      pulse_dat(8'h11);
      step(S + 6);
      pulse_rd();
      pulse_dat(8'h22);
      pulse_idx(8'h33);
      step(S + ND + NI + ND + 60);
      check(lg_kind.size() == 4, "R9", "access count", lg_kind.size(), 4);
      if (lg_kind.size() == 4) begin
         check(lg_kind[1] == 1 && lg_byte[1] == 8'h33, "R9", "index first", lg_kind[1], 1);
         check(lg_kind[2] == 2 && lg_byte[2] == 8'h22, "R9", "data second", lg_kind[2], 2);
         check(lg_kind[3] == 3, "R9", "read last", lg_kind[3], 3);
      end

      // R3 alone: index only, wait drops after the index settle
      clear_log();
      pulse_idx(8'h44);
      step(S + NI + 10);
      check(!host_wait && wait_falls == 1, "R3", "wait after lone index", host_wait, 0);

      // R10: reset during a transaction drops everything
      clear_log();
      pulse_idx(8'h55);
      pulse_dat(8'h66);
      step(S + 20);
      rst_n = 1'b0;
      step(2);
      check(!host_wait, "R10", "wait in reset", host_wait, 0);
      rst_n = 1'b1;
      step(ND + 50);
      check(lg_kind.size() == 1, "R10", "no write after reset", lg_kind.size(), 1);
      check(!host_wait && fm_cs_n, "R10", "idle after reset", {host_wait, fm_cs_n}, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule